// File: doc/BRIEF.md
# Split-Mode Period Timer with Gated Interrupt

This block is a timer whose count register can be operated as two independent halves, each with its own counter and period register. Software configures it through a small register port. The port offers a control word, a counter and a period for each half, and an interrupt control and status word. Each half can be held in reset on its own. Once released, a half can be left idle, run for one period and then stop, or run continuously with a reload to zero after every match.

When a running half's counter equals its period, that half sets a sticky status bit and emits a one-cycle DMA event pulse. It may also emit a one-cycle interrupt pulse. Whether the per-half interrupt enable has any effect depends on a global extended-control bit. With that bit clear, the interrupt fires on every match whatever the enable holds. With it set, an enable of zero suppresses the interrupt. The DMA event and the status bit are never masked.

Only the split (two independent halves) operation counts. With the split bit clear, both halves hold their value.

Top module: `dual_timer`

## Requirements
- R1: After the asynchronous reset, every register reads zero and both interrupt and DMA outputs are low, so both halves start in reset with the extended bit clear.
- R2: With control bit 0 (split) clear, neither half counts or raises events, even when released with a running mode.
- R3: A half whose run bit (control bit 2 for the lower half, bit 3 for the upper half) is 0 holds its counter at zero, ignores counter writes and raises no events.
- R4: Mode 2'b01 (run once; mode field bits 5:4 for the lower half, 7:6 for the upper half) counts up from zero by one per cycle. The first match pulse appears period+1 cycles after the release. The counter then stops and holds the period value.
- R5: Mode 2'b10 (continuous) reloads the counter to zero on the cycle after each match and keeps counting, so matches repeat every period+1 cycles. Modes 2'b00 and 2'b11 hold the counter.
- R6: A match sets the half's status bit (interrupt word bit 8 for the lower half, bit 9 for the upper half). The bit stays set until a 1 is written to it. Writing 0 leaves it unchanged.
- R7: Every match produces exactly one single-cycle DMA event pulse on that half's DMA output bit.
- R8: With control bit 1 (extended) clear, every match produces a single-cycle interrupt pulse, regardless of the interrupt enable (interrupt word bit 0 for the lower half, bit 1 for the upper half).
- R9: With the extended bit set, a match produces an interrupt pulse only when that half's interrupt enable is 1.
- R10: The two halves count, match and signal independently, each with its own period, mode and enable.
- R11: The register map is: 0 control, 1 lower counter, 2 upper counter, 3 lower period, 4 upper period, 5 interrupt word. Reads are combinational and unused bits read zero.
- R12: A counter written above its period wraps through zero at the counter width and matches when it comes back around to the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 2 | Interrupt pulse per half (bit 0 lower) |
| dma_o | output | 2 | DMA event pulse per half (bit 0 lower) |

## Verification
The bench builds the block with an 8-bit counter width instead of the default 32. This brings counter wraparound within reach: a counter written just above its period goes all the way round in 256 cycles, so the wrap path of R12 is checked directly. Periods of 0, 2, 3, 5 and 6 cover back-to-back matches in continuous mode, and short one-shot runs. All four combinations of the extended bit and the interrupt enable are covered.

// File: rtl/dual_timer_pkg.sv
package dual_timer_pkg;
  localparam int ADDR_W     = 3;
  localparam int DATA_W     = 32;
  localparam int NUM_HALVES = 2;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_ONCE = 2'b01,
    MODE_CONT = 2'b10,
    MODE_RSVD = 2'b11
  } run_mode_e;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd2;
  localparam logic [ADDR_W-1:0] A_PRD_LO = 3'd3;
  localparam logic [ADDR_W-1:0] A_PRD_HI = 3'd4;
  localparam logic [ADDR_W-1:0] A_INT    = 3'd5;

  localparam int C_SPLIT   = 0;
  localparam int C_EXT     = 1;
  localparam int C_RUN0    = 2;
  localparam int C_MODE0   = 4;
  localparam int CTRL_W    = C_MODE0 + 2 * NUM_HALVES;
  localparam int INT_IEN0  = 0;
  localparam int INT_STAT0 = 8;
endpackage

// File: rtl/dual_timer_regs.sv
module dual_timer_regs
  import dual_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                we_i,
  input  logic [ADDR_W-1:0]                   addr_i,
  input  logic [DATA_W-1:0]                   wdata_i,
  output logic [DATA_W-1:0]                   rdata_o,
  input  logic [NUM_HALVES-1:0]               hit_i,
  input  logic [NUM_HALVES-1:0][CNT_W-1:0]    cnt_i,
  output logic                                split_o,
  output logic                                ext_o,
  output logic [NUM_HALVES-1:0]               run_o,
  output logic [NUM_HALVES-1:0][1:0]          mode_o,
  output logic [NUM_HALVES-1:0]               ien_o,
  output logic [NUM_HALVES-1:0]               stat_o,
  output logic [NUM_HALVES-1:0][CNT_W-1:0]    prd_o,
  output logic [NUM_HALVES-1:0]               cnt_we_o,
  output logic [CNT_W-1:0]                    cnt_wdata_o
);
  logic [CTRL_W-1:0]     ctrl_q;
  logic [NUM_HALVES-1:0] ien_q;
  logic [NUM_HALVES-1:0] stat_q;
  logic                  wr_ctrl, wr_int;
  logic                  unused_wdata;

  assign wr_ctrl      = we_i && (addr_i == A_CTRL);
  assign wr_int       = we_i && (addr_i == A_INT);
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ien_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata_i[CTRL_W-1:0];
      if (wr_int)  ien_q  <= wdata_i[INT_IEN0 +: NUM_HALVES];
    end
  end

  assign split_o     = ctrl_q[C_SPLIT];
  assign ext_o       = ctrl_q[C_EXT];
  assign ien_o       = ien_q;
  assign stat_o      = stat_q;
  assign cnt_wdata_o = wdata_i[CNT_W-1:0];

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    localparam logic [ADDR_W-1:0] CNT_A = A_CNT_LO + ADDR_W'(h);
    localparam logic [ADDR_W-1:0] PRD_A = A_PRD_LO + ADDR_W'(h);
    logic [CNT_W-1:0] prd_q;
    logic             clr;

    assign run_o[h]    = ctrl_q[C_RUN0 + h];
    assign mode_o[h]   = ctrl_q[C_MODE0 + 2*h +: 2];
    assign cnt_we_o[h] = we_i && (addr_i == CNT_A);
    assign prd_o[h]    = prd_q;
    assign clr         = wr_int && wdata_i[INT_STAT0 + h];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prd_q     <= '0;
        stat_q[h] <= 1'b0;
      end else begin
        if (we_i && (addr_i == PRD_A)) prd_q <= wdata_i[CNT_W-1:0];
        if (hit_i[h])  stat_q[h] <= 1'b1;   // set beats clear
        else if (clr)  stat_q[h] <= 1'b0;
      end
    end

    // R6
    stat_w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr && !hit_i[h]) |=> !stat_q[h]);
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL:   rdata_o[CTRL_W-1:0] = ctrl_q;
      A_CNT_LO: rdata_o[CNT_W-1:0]  = cnt_i[0];
      A_CNT_HI: rdata_o[CNT_W-1:0]  = cnt_i[1];
      A_PRD_LO: rdata_o[CNT_W-1:0]  = g_half[0].prd_q;
      A_PRD_HI: rdata_o[CNT_W-1:0]  = g_half[1].prd_q;
      A_INT: begin
        rdata_o[INT_IEN0  +: NUM_HALVES] = ien_q;
        rdata_o[INT_STAT0 +: NUM_HALVES] = stat_q;
      end
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dual_timer_half.sv
module dual_timer_half
  import dual_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             split_i,
  input  logic             run_i,
  input  run_mode_e        mode_i,
  input  logic [CNT_W-1:0] prd_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             active;

  assign active = split_i && run_i &&
                  ((mode_i == MODE_ONCE && !done_q) || mode_i == MODE_CONT);
  assign hit_o  = active && !wr_i && (cnt_q == prd_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (mode_i != MODE_ONCE) done_q <= 1'b0;
      else if (hit_o)          done_q <= 1'b1;

      if (wr_i)                cnt_q <= wdata_i;
      else if (hit_o) begin
        if (mode_i == MODE_CONT) cnt_q <= '0;
      end
      else if (active)         cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R3
  held_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_o == '0));

  // R4
  once_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && run_i && mode_i == MODE_ONCE && !wr_i) |=> $stable(cnt_o));
endmodule

// File: rtl/dual_timer_evt.sv
module dual_timer_evt (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic ext_i,
  input  logic ien_i,
  output logic irq_o,
  output logic dma_o
);
  logic irq_q, dma_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      dma_q <= 1'b0;
    end else begin
      dma_q <= hit_i;
      // enable only matters in extended mode
      irq_q <= hit_i && (!ext_i || ien_i);
    end
  end

  assign irq_o = irq_q;
  assign dma_o = dma_q;

  // R8
  legacy_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && !ext_i) |=> irq_o);

  // R9
  masked_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_i && !ien_i) |=> !irq_o);
endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import dual_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  output logic [NUM_HALVES-1:0] irq_o,
  output logic [NUM_HALVES-1:0] dma_o
);
  logic                             split, ext;
  logic [NUM_HALVES-1:0]            run, ien, stat, hit, cnt_we;
  logic [NUM_HALVES-1:0][1:0]       mode;
  logic [NUM_HALVES-1:0][CNT_W-1:0] prd, cnt;
  logic [CNT_W-1:0]                 cnt_wdata;

  dual_timer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o,
    .hit_i(hit), .cnt_i(cnt),
    .split_o(split), .ext_o(ext), .run_o(run), .mode_o(mode),
    .ien_o(ien), .stat_o(stat), .prd_o(prd),
    .cnt_we_o(cnt_we), .cnt_wdata_o(cnt_wdata)
  );

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    dual_timer_half #(.CNT_W(CNT_W)) u_half (
      .clk_i, .rst_ni,
      .split_i(split), .run_i(run[h]), .mode_i(run_mode_e'(mode[h])),
      .prd_i(prd[h]), .wr_i(cnt_we[h]), .wdata_i(cnt_wdata),
      .cnt_o(cnt[h]), .hit_o(hit[h])
    );

    dual_timer_evt u_evt (
      .clk_i, .rst_ni,
      .hit_i(hit[h]), .ext_i(ext), .ien_i(ien[h]),
      .irq_o(irq_o[h]), .dma_o(dma_o[h])
    );

    // R6
    dma_sets_stat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dma_o[h] |-> stat[h]);

    // R3
    held_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run[h] |=> !dma_o[h] && !irq_o[h]);

    // R2
    split_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !split |=> !dma_o[h]);
  end
endmodule

// File: tb/dual_timer_test.sv
`timescale 1ns/1ps
module dual_timer_test;
  localparam int CW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq, dma;

  dual_timer #(.CNT_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .dma_o(dma)
  );

  always #10 clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  typedef struct packed {
    logic       ext;
    logic       ien;
    logic [1:0] mode;
    logic [7:0] prd;
    logic [7:0] win;
    logic [3:0] exp_dma;
    logic [3:0] exp_irq;
    logic [7:0] exp_lat;
  } vec_t;

  // R4 once, R5 continuous, R8 extended clear, R9 extended set
  localparam vec_t VECS [7] = '{
    '{1'b0, 1'b0, 2'b01, 8'd5, 8'd20, 4'd1, 4'd1, 8'd6},
    '{1'b1, 1'b0, 2'b01, 8'd5, 8'd20, 4'd1, 4'd0, 8'd6},
    '{1'b1, 1'b1, 2'b01, 8'd2, 8'd20, 4'd1, 4'd1, 8'd3},
    '{1'b0, 1'b1, 2'b10, 8'd3, 8'd12, 4'd3, 4'd3, 8'd4},
    '{1'b1, 1'b0, 2'b10, 8'd3, 8'd12, 4'd3, 4'd0, 8'd4},
    '{1'b0, 1'b0, 2'b01, 8'd0, 8'd10, 4'd1, 4'd1, 8'd1},
    '{1'b1, 1'b1, 2'b10, 8'd0, 8'd5,  4'd5, 4'd5, 8'd1}
  };

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrl(input bit split, input bit ext, input bit run0,
                                       input bit run1, input logic [1:0] m0, input logic [1:0] m1);
    return {24'd0, m1, m0, run1, run0, ext, split};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic win(input int n, output int dc0, output int dc1, output int ic0,
                     output int ic1, output int f0, output int f1);
    dc0 = 0; dc1 = 0; ic0 = 0; ic1 = 0; f0 = 0; f1 = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (dma[0]) begin dc0++; if (f0 == 0) f0 = i; end
      if (dma[1]) begin dc1++; if (f1 == 0) f1 = i; end
      if (irq[0]) ic0++;
      if (irq[1]) ic1++;
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int dc0, dc1, ic0, ic1, f0, f1;

    repeat (3) @(negedge clk);
    check("R1", "irq in reset", irq, 0);
    check("R1", "dma in reset", dma, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R11: all six registers read zero
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      check("R11", $sformatf("reg %0d after reset", a), d, 0);
    end

    // R2: released but split clear
    wr(3'd3, 32'd2);
    wr(3'd0, ctrl(0, 0, 1, 1, 2'b10, 2'b10));
    win(10, dc0, dc1, ic0, ic1, f0, f1);
    rd(3'd1, d);
    check("R2", "count without split", d, 0);
    check("R2", "dma without split", dc0 + dc1, 0);

    // R3: split set, half held, counter write ignored
    wr(3'd0, ctrl(1, 0, 0, 0, 2'b01, 2'b10));
    wr(3'd1, 32'd7);
    win(10, dc0, dc1, ic0, ic1, f0, f1);
    rd(3'd1, d);
    check("R3", "held count", d, 0);
    check("R3", "held events", dc0 + dc1 + ic0 + ic1, 0);

    // Vector table: R4 R5 R6 R7 R8 R9
    foreach (VECS[k]) begin
      vec_t v = VECS[k];
      wr(3'd0, ctrl(1, v.ext, 0, 0, 2'b00, 2'b00));
      wr(3'd5, 32'h300);
      wr(3'd3, {24'd0, v.prd});
      wr(3'd5, {31'd0, v.ien});
      wr(3'd0, ctrl(1, v.ext, 1, 0, v.mode, 2'b00));
      win(int'(v.win), dc0, dc1, ic0, ic1, f0, f1);
      rd(3'd1, d);
      if (v.mode == 2'b01)
        check("R4", $sformatf("vec %0d final count", k), d, v.prd);
      else
        check("R5", $sformatf("vec %0d final count", k), d, int'(v.win) % (int'(v.prd) + 1));
      check("R4", $sformatf("vec %0d first match latency", k), f0, v.exp_lat);
      check("R7", $sformatf("vec %0d dma pulses", k), dc0, v.exp_dma);
      check(v.ext ? "R9" : "R8", $sformatf("vec %0d irq pulses", k), ic0, v.exp_irq);
      rd(3'd5, d);
      check("R6", $sformatf("vec %0d status", k), d[8], 1);
    end

    // R10: halves independent, extended on, lower masked, upper enabled
    wr(3'd0, ctrl(1, 1, 0, 0, 2'b00, 2'b00));
    wr(3'd5, 32'h300);
    wr(3'd3, 32'd2);
    wr(3'd4, 32'd6);
    wr(3'd5, 32'h2);
    wr(3'd0, ctrl(1, 1, 1, 1, 2'b01, 2'b10));
    win(20, dc0, dc1, ic0, ic1, f0, f1);
    check("R10", "lower latency", f0, 3);
    check("R10", "lower dma", dc0, 1);
    check("R10", "lower irq masked", ic0, 0);
    check("R10", "upper latency", f1, 7);
    check("R10", "upper dma", dc1, 2);
    check("R10", "upper irq", ic1, 2);
    rd(3'd2, d);
    check("R10", "upper count", d, 20 % 7);

    // R12: wraparound at 8 bits
    wr(3'd0, ctrl(1, 0, 0, 0, 2'b00, 2'b00));
    wr(3'd5, 32'h300);
    wr(3'd0, ctrl(1, 0, 1, 0, 2'b00, 2'b00));
    wr(3'd3, 32'd4);
    wr(3'd1, 32'd5);
    rd(3'd1, d);
    check("R5", "idle mode holds written count", d, 5);
    wr(3'd0, ctrl(1, 0, 1, 0, 2'b01, 2'b00));
    win(300, dc0, dc1, ic0, ic1, f0, f1);
    check("R12", "wrap latency", f0, 256);
    check("R12", "wrap dma", dc0, 1);

    // R6: status persists, write of 0 keeps it, write of 1 clears
    repeat (5) @(negedge clk);
    rd(3'd5, d);
    check("R6", "status persists", d[8], 1);
    wr(3'd5, 32'h0);
    rd(3'd5, d);
    check("R6", "write 0 keeps status", d[8], 1);
    wr(3'd5, 32'h100);
    rd(3'd5, d);
    check("R6", "write 1 clears status", d[8], 0);
    rd(3'd0, d);
    check("R11", "control readback", d, ctrl(1, 0, 1, 0, 2'b01, 2'b00));

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule